// File: doc/BRIEF.md
# Wavefront Local Alignment Scorer

This block finds the best local alignment score between a target string of up to `MAX_T` symbols and a query string of up to `MAX_Q` symbols. Gaps are charged with an affine cost, a one-time opening charge plus a per-symbol extension charge. Matching symbols add a programmable reward and differing symbols subtract a programmable penalty. All scores are unsigned 16-bit values that saturate, and the floor of zero is what makes the alignment local.

Before a run, software writes the two strings symbol by symbol through a small write port. A start pulse then captures the two lengths and the four scoring values. The block sweeps the score matrix one anti-diagonal at a time. `LANES` cell units work side by side on the cells of the current diagonal, from the highest row down. Buffers indexed by row carry the last two diagonals of cell scores and the last diagonal of both gap terms. When the last diagonal is finished, a one-cycle done pulse reports the highest cell score and its row (query position) and column (target position). These results stay on the outputs until the next start.

Top module: `sw_diag_aligner`

## Requirements
- R1: The score of cell (r, c) is the largest of: the score of cell (r-1, c-1) plus `match_sc` when query symbol r equals target symbol c, or minus `mism_pen` when they differ; the horizontal gap term; the vertical gap term; and zero. Identical strings of length L score L times `match_sc`, reported at (L, L).
- R2: The horizontal gap term of (r, c) is the larger of the horizontal gap term of (r, c-1) minus `gap_ext` and the score of (r, c-1) minus (`gap_open` + `gap_ext`). The vertical gap term is built in the same way from cell (r-1, c). Any cell with row or column 0 counts as zero.
- R3: Every addition saturates at 65535 and every subtraction saturates at 0, so no score wraps around.
- R4: When no cell scores above zero, the result is score 0 at row 0, column 0.
- R5: The reported cell is the first cell to reach the maximum, in order of diagonal index (row + column − 1) and then by lowest row within one diagonal.
- R6: Any lengths from 1 to the maximum give the correct result, including diagonals whose cell count is not a multiple of `LANES`. Lanes with no cell to compute change nothing.
- R7: A start pulse while `busy` is high is ignored. The run in progress goes on with the lengths and scoring values captured when it began.
- R8: `done` is high for exactly one cycle. `busy` is low while `done` is high. `best_score`, `best_row` and `best_col` do not change from `done` until the next accepted start, even if the symbol stores are written meanwhile.
- R9: A start with either length equal to 0 raises `done` one cycle later with score 0 at (0, 0), and `busy` stays low.
- R10: A write through the load port while `busy` is high is ignored. The symbol stores keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one symbol this cycle |
| ld_sel | input | 1 | 0 selects the target store, 1 selects the query store |
| ld_addr | input | AW | Symbol position, counted from 0 |
| ld_sym | input | SYM_W | Symbol code |
| tgt_len | input | CW | Target length, 0 to MAX_T, captured at start |
| qry_len | input | RW | Query length, 0 to MAX_Q, captured at start |
| match_sc | input | 16 | Reward for equal symbols, captured at start |
| mism_pen | input | 16 | Penalty for different symbols, captured at start |
| gap_open | input | 16 | Gap opening charge, captured at start |
| gap_ext | input | 16 | Gap extension charge, captured at start |
| start | input | 1 | Begin a run (ignored while busy) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| best_score | output | 16 | Highest cell score |
| best_row | output | RW | Query position of the reported cell |
| best_col | output | CW | Target position of the reported cell |

## Verification
The tie rule is the hardest behaviour to reach from the ports. It matters when two equal maxima sit on the same diagonal but in different lane groups. Because the sweep runs from high rows to low rows, the winning low-row cell is produced after the other one. The bench builds a 5 by 5 case in which the only two matching pairs lie on diagonal 5, at rows 1 and 5, so that they fall into separate cycles. Separate cases cover start pulses and load writes injected in the middle of a long 16 by 16 run. For the load case the same run is started again, to show that the stores were left alone.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int SCORE_W = 16;
    typedef logic [SCORE_W-1:0] score_t;

    function automatic score_t sat_add(score_t a, score_t b);
        logic [SCORE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SCORE_W] ? '1 : s[SCORE_W-1:0];
    endfunction

    function automatic score_t sat_sub(score_t a, score_t b);
        return (a > b) ? a - b : '0;
    endfunction

    function automatic score_t smax(score_t a, score_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sw_cell.sv
module sw_cell
    import sw_pkg::*;
#(
    parameter int SYM_W = 2
) (
    input  logic [SYM_W-1:0] t_sym,
    input  logic [SYM_W-1:0] q_sym,
    input  score_t           h_diag,
    input  score_t           h_left,
    input  score_t           e_left,
    input  score_t           h_up,
    input  score_t           f_up,
    input  score_t           match_sc,
    input  score_t           mism_pen,
    input  score_t           open_ext,
    input  score_t           gap_ext,
    output score_t           h_o,
    output score_t           e_o,
    output score_t           f_o
);
    score_t sub_v;

    always_comb begin
        sub_v = (t_sym == q_sym) ? sat_add(h_diag, match_sc) : sat_sub(h_diag, mism_pen);
        e_o   = smax(sat_sub(e_left, gap_ext), sat_sub(h_left, open_ext));
        f_o   = smax(sat_sub(f_up, gap_ext), sat_sub(h_up, open_ext));
        h_o   = smax(sub_v, smax(e_o, f_o));
    end
endmodule

// File: rtl/sw_best_merge.sv
module sw_best_merge
    import sw_pkg::*;
#(
    parameter int LANES = 4,
    parameter int RW    = 5,
    parameter int CW    = 5,
    parameter int DW    = 5
) (
    input  logic [LANES-1:0]          lane_ok,
    input  logic [LANES-1:0][15:0]    lane_h,
    input  logic [LANES-1:0][RW-1:0]  lane_row,
    input  logic [LANES-1:0][CW-1:0]  lane_col,
    input  logic [DW-1:0]             cur_d,
    input  score_t                    in_score,
    input  logic [RW-1:0]             in_row,
    input  logic [CW-1:0]             in_col,
    input  logic [DW-1:0]             in_diag,
    output score_t                    out_score,
    output logic [RW-1:0]             out_row,
    output logic [CW-1:0]             out_col,
    output logic [DW-1:0]             out_diag
);
    always_comb begin
        out_score = in_score;
        out_row   = in_row;
        out_col   = in_col;
        out_diag  = in_diag;
        for (int k = 0; k < LANES; k++) begin
            if (lane_ok[k] && ((lane_h[k] > out_score) ||
                ((lane_h[k] == out_score) && (out_diag == cur_d) && (lane_row[k] < out_row)))) begin
                out_score = lane_h[k];
                out_row   = lane_row[k];
                out_col   = lane_col[k];
                out_diag  = cur_d;
            end
        end
    end
endmodule

// File: rtl/sw_diag_aligner.sv
module sw_diag_aligner
    import sw_pkg::*;
#(
    parameter int MAX_T = 16,
    parameter int MAX_Q = 16,
    parameter int LANES = 4,
    parameter int SYM_W = 2,
    localparam int RW = $clog2(MAX_Q + 1),
    localparam int CW = $clog2(MAX_T + 1),
    localparam int DW = $clog2(MAX_T + MAX_Q),
    localparam int AW = $clog2((MAX_T > MAX_Q) ? MAX_T : MAX_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [AW-1:0]    ld_addr,
    input  logic [SYM_W-1:0] ld_sym,
    input  logic [CW-1:0]    tgt_len,
    input  logic [RW-1:0]    qry_len,
    input  logic [15:0]      match_sc,
    input  logic [15:0]      mism_pen,
    input  logic [15:0]      gap_open,
    input  logic [15:0]      gap_ext,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [15:0]      best_score,
    output logic [RW-1:0]    best_row,
    output logic [CW-1:0]    best_col
);
    typedef struct packed {
        logic                            busy;
        logic                            done;
        logic [DW-1:0]                   d;
        logic [RW-1:0]                   base;
        logic [RW-1:0]                   rs;
        logic [CW-1:0]                   tl;
        logic [RW-1:0]                   ql;
        score_t                          mat;
        score_t                          mis;
        score_t                          opx;
        score_t                          ext;
        logic [MAX_T-1:0][SYM_W-1:0]     tmem;
        logic [MAX_Q-1:0][SYM_W-1:0]     qmem;
        logic [MAX_Q:0][SCORE_W-1:0]     h1;
        logic [MAX_Q:0][SCORE_W-1:0]     h2;
        logic [MAX_Q:0][SCORE_W-1:0]     e1;
        logic [MAX_Q:0][SCORE_W-1:0]     f1;
        score_t                          bscore;
        logic [RW-1:0]                   brow;
        logic [CW-1:0]                   bcol;
        logic [DW-1:0]                   bdiag;
    } state_t;

    state_t q, d_n;

    logic [LANES-1:0]          lane_ok;
    logic [LANES-1:0][15:0]    lane_h, lane_e, lane_f;
    logic [LANES-1:0][RW-1:0]  lane_row;
    logic [LANES-1:0][CW-1:0]  lane_col;
    score_t                    mg_score;
    logic [RW-1:0]             mg_row;
    logic [CW-1:0]             mg_col;
    logic [DW-1:0]             mg_diag;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        int               row_i, col_i;
        logic             ok;
        logic [RW-1:0]    r;
        logic [CW-1:0]    c;
        logic [SYM_W-1:0] ts, qs;
        score_t           hd, hl, el, hu, fu, ho, eo, fo;

        always_comb begin
            row_i = int'(q.base) - k;
            col_i = int'(q.d) - row_i + 1;
            ok    = q.busy && (row_i >= int'(q.rs));
            r     = ok ? RW'(row_i) : '0;
            c     = ok ? CW'(col_i) : '0;
            ts    = ok ? q.tmem[c - CW'(1)] : '0;
            qs    = ok ? q.qmem[r - RW'(1)] : '0;
            hd    = ok ? q.h2[r - RW'(1)] : '0;
            hu    = ok ? q.h1[r - RW'(1)] : '0;
            fu    = ok ? q.f1[r - RW'(1)] : '0;
            hl    = q.h1[r];
            el    = q.e1[r];
        end

        sw_cell #(.SYM_W(SYM_W)) u_cell (
            .t_sym(ts), .q_sym(qs), .h_diag(hd), .h_left(hl), .e_left(el),
            .h_up(hu), .f_up(fu), .match_sc(q.mat), .mism_pen(q.mis),
            .open_ext(q.opx), .gap_ext(q.ext), .h_o(ho), .e_o(eo), .f_o(fo)
        );

        assign lane_ok[k]  = ok;
        assign lane_row[k] = r;
        assign lane_col[k] = c;
        assign lane_h[k]   = ho;
        assign lane_e[k]   = eo;
        assign lane_f[k]   = fo;
    end

    sw_best_merge #(.LANES(LANES), .RW(RW), .CW(CW), .DW(DW)) u_merge (
        .lane_ok(lane_ok), .lane_h(lane_h), .lane_row(lane_row), .lane_col(lane_col),
        .cur_d(q.d), .in_score(q.bscore), .in_row(q.brow), .in_col(q.bcol),
        .in_diag(q.bdiag), .out_score(mg_score), .out_row(mg_row),
        .out_col(mg_col), .out_diag(mg_diag)
    );

    always_comb begin
        int nd, re, rs;
        d_n      = q;
        d_n.done = 1'b0;
        nd = int'(q.d) + 1;
        re = (nd < int'(q.ql)) ? nd : int'(q.ql);
        rs = (nd - int'(q.tl) + 1 > 1) ? nd - int'(q.tl) + 1 : 1;

        if (ld_en && !q.busy) begin
            if (ld_sel) d_n.qmem[ld_addr] = ld_sym;
            else        d_n.tmem[ld_addr] = ld_sym;
        end

        if (!q.busy) begin
            if (start) begin
                d_n.tl     = tgt_len;
                d_n.ql     = qry_len;
                d_n.mat    = match_sc;
                d_n.mis    = mism_pen;
                d_n.opx    = sat_add(gap_open, gap_ext);
                d_n.ext    = gap_ext;
                d_n.h1     = '0;
                d_n.h2     = '0;
                d_n.e1     = '0;
                d_n.f1     = '0;
                d_n.bscore = '0;
                d_n.brow   = '0;
                d_n.bcol   = '0;
                d_n.bdiag  = '0;
                d_n.d      = DW'(1);
                d_n.base   = RW'(1);
                d_n.rs     = RW'(1);
                if (tgt_len == '0 || qry_len == '0) d_n.done = 1'b1;
                else                                d_n.busy = 1'b1;
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_ok[k]) begin
                    d_n.h2[lane_row[k]] = q.h1[lane_row[k]];
                    d_n.h1[lane_row[k]] = lane_h[k];
                    d_n.e1[lane_row[k]] = lane_e[k];
                    d_n.f1[lane_row[k]] = lane_f[k];
                end
            end
            d_n.bscore = mg_score;
            d_n.brow   = mg_row;
            d_n.bcol   = mg_col;
            d_n.bdiag  = mg_diag;
            if (int'(q.base) - LANES < int'(q.rs)) begin
                if (int'(q.d) == int'(q.tl) + int'(q.ql) - 1) begin
                    d_n.busy = 1'b0;
                    d_n.done = 1'b1;
                end else begin
                    d_n.d    = DW'(nd);
                    d_n.base = RW'(re);
                    d_n.rs   = RW'(rs);
                end
            end else begin
                d_n.base = q.base - RW'(LANES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d_n;
    end

    assign busy       = q.busy;
    assign done       = q.done;
    assign best_score = q.bscore;
    assign best_row   = q.brow;
    assign best_col   = q.bcol;
endmodule

// File: rtl/sw_diag_aligner_chk.sv
module sw_diag_aligner_chk #(
    parameter int RW = 5,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [15:0]   best_score,
    input logic [RW-1:0] best_row,
    input logic [CW-1:0] best_col
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(best_score) && $stable(best_row) && $stable(best_col)));

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (best_score >= $past(best_score)));

    p_zero_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && best_score == 16'd0) |-> (best_row == '0 && best_col == '0));

    p_coord_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && best_score != 16'd0) |-> (best_row != '0 && best_col != '0));
endmodule

bind sw_diag_aligner sw_diag_aligner_chk #(.RW(RW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .best_score(best_score), .best_row(best_row), .best_col(best_col)
);

// File: tb/sw_diag_aligner_bench.sv
module sw_diag_aligner_bench;
    localparam int MT = 16;
    localparam int MQ = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0, ld_sel = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [1:0]  ld_sym = '0;
    logic [4:0]  tgt_len = '0, qry_len = '0;
    logic [15:0] match_sc = '0, mism_pen = '0, gap_open = '0, gap_ext = '0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [15:0] best_score;
    logic [4:0]  best_row, best_col;

    int checks = 0, fails = 0, cycles = 0;
    int tseq [MT];
    int qseq [MQ];

    always #2 clk = ~clk;

    sw_diag_aligner #(.MAX_T(MT), .MAX_Q(MQ), .LANES(4), .SYM_W(2)) u_sw_diag_aligner (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .ld_sym(ld_sym), .tgt_len(tgt_len), .qry_len(qry_len), .match_sc(match_sc),
        .mism_pen(mism_pen), .gap_open(gap_open), .gap_ext(gap_ext), .start(start),
        .busy(busy), .done(done), .best_score(best_score), .best_row(best_row),
        .best_col(best_col)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clamp(input int v);
        return (v < 0) ? 0 : ((v > 65535) ? 65535 : v);
    endfunction

    // Row-by-row model: scan order picks the first maximum by diagonal, then lowest row.
    task automatic model(input int tl, input int ql, input int m, input int mm,
                         input int go, input int ge, output int bs, output int br, output int bc);
        int h [0:MQ][0:MT];
        int e [0:MQ][0:MT];
        int f [0:MQ][0:MT];
        int ox;
        ox = clamp(go + ge);
        for (int r = 0; r <= MQ; r++)
            for (int c = 0; c <= MT; c++) begin h[r][c] = 0; e[r][c] = 0; f[r][c] = 0; end
        for (int r = 1; r <= ql; r++)
            for (int c = 1; c <= tl; c++) begin
                int dg;
                dg = clamp(h[r-1][c-1] + ((qseq[r-1] == tseq[c-1]) ? m : -mm));
                e[r][c] = clamp(e[r][c-1] - ge);
                if (clamp(h[r][c-1] - ox) > e[r][c]) e[r][c] = clamp(h[r][c-1] - ox);
                f[r][c] = clamp(f[r-1][c] - ge);
                if (clamp(h[r-1][c] - ox) > f[r][c]) f[r][c] = clamp(h[r-1][c] - ox);
                h[r][c] = dg;
                if (e[r][c] > h[r][c]) h[r][c] = e[r][c];
                if (f[r][c] > h[r][c]) h[r][c] = f[r][c];
            end
        bs = 0; br = 0; bc = 0;
        for (int d = 1; d <= tl + ql - 1; d++)
            for (int r = 1; r <= ql; r++) begin
                int c;
                c = d - r + 1;
                if (c >= 1 && c <= tl && h[r][c] > bs) begin bs = h[r][c]; br = r; bc = c; end
            end
    endtask

    task automatic write_sym(input bit sel, input int addr, input int sym);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = 4'(addr); ld_sym = 2'(sym);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all(input int tl, input int ql);
        for (int i = 0; i < tl; i++) write_sym(1'b0, i, tseq[i]);
        for (int i = 0; i < ql; i++) write_sym(1'b1, i, qseq[i]);
    endtask

    task automatic set_cfg(input int tl, input int ql, input int m, input int mm,
                           input int go, input int ge);
        tgt_len = 5'(tl); qry_len = 5'(ql);
        match_sc = 16'(m); mism_pen = 16'(mm); gap_open = 16'(go); gap_ext = 16'(ge);
    endtask

    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        check(done == 1'b1, tag, done, 1);
    endtask

    task automatic run_and_compare(input int tl, input int ql, input int m, input int mm,
                                   input int go, input int ge, input string tag);
        int bs, br, bc;
        model(tl, ql, m, mm, go, ge, bs, br, bc);
        load_all(tl, ql);
        set_cfg(tl, ql, m, mm, go, ge);
        kick();
        wait_done(tag);
        check(best_score == 16'(bs), tag, best_score, bs);
        check(best_row == 5'(br), tag, best_row, br);
        check(best_col == 5'(bc), tag, best_col, bc);
    endtask

    task automatic t_reset();
        check(busy == 1'b0 && done == 1'b0, "R8 reset idle", busy, 0);
        check(best_score == 16'd0, "R4 reset score", best_score, 0);
    endtask

    task automatic t_identical_r1();
        for (int i = 0; i < 6; i++) begin tseq[i] = i % 4; qseq[i] = i % 4; end
        run_and_compare(6, 6, 3, 2, 4, 1, "R1 identical");
        check(best_score == 16'd18 && best_row == 5'd6 && best_col == 5'd6,
              "R1 identical hand value", best_score, 18);
    endtask

    task automatic t_gap_r2();
        tseq[0] = 0; tseq[1] = 1; tseq[2] = 2; tseq[3] = 3;
        qseq[0] = 0; qseq[1] = 1; qseq[2] = 3;
        run_and_compare(4, 3, 5, 4, 3, 1, "R2 gap");
        check(best_score == 16'd11 && best_row == 5'd3 && best_col == 5'd4,
              "R2 gap hand value", best_score, 11);
    endtask

    task automatic t_saturate_r3();
        for (int i = 0; i < 16; i++) begin tseq[i] = 1; qseq[i] = 1; end
        run_and_compare(16, 16, 8000, 1, 1, 1, "R3 saturate");
        check(best_score == 16'hFFFF && best_row == 5'd9 && best_col == 5'd9,
              "R3 saturate hand value", best_score, 65535);
    endtask

    task automatic t_nomatch_r4();
        for (int i = 0; i < 7; i++) begin tseq[i] = 0; qseq[i] = 2; end
        run_and_compare(7, 5, 9, 3, 2, 1, "R4 no match");
        check(best_score == 16'd0 && best_row == 5'd0 && best_col == 5'd0,
              "R4 zero origin", best_row, 0);
    endtask

    task automatic t_ties_r5();
        tseq[0] = 1; tseq[1] = 0; qseq[0] = 0; qseq[1] = 1;
        run_and_compare(2, 2, 3, 5, 5, 5, "R5 tie same cycle");
        check(best_row == 5'd1 && best_col == 5'd2, "R5 tie same cycle row", best_row, 1);
        tseq[0] = 2; tseq[1] = 3; tseq[2] = 3; tseq[3] = 3; tseq[4] = 0;
        qseq[0] = 0; qseq[1] = 1; qseq[2] = 1; qseq[3] = 1; qseq[4] = 2;
        run_and_compare(5, 5, 4, 9, 9, 9, "R5 tie across groups");
        check(best_row == 5'd1 && best_col == 5'd5, "R5 tie across groups row", best_row, 1);
        tseq[0] = 0; tseq[1] = 0; qseq[0] = 0;
        run_and_compare(2, 1, 3, 1, 1, 1, "R5 tie earlier diagonal");
        check(best_col == 5'd1, "R5 tie earlier diagonal col", best_col, 1);
    endtask

    task automatic t_lengths_r6();
        int tl, ql;
        for (int n = 0; n < 8; n++) begin
            tl = (n == 0) ? 1 : ((n == 1) ? 5 : ((n == 2) ? 16 : 1 + ($urandom % 16)));
            ql = (n == 0) ? 1 : ((n == 1) ? 3 : ((n == 2) ? 16 : 1 + ($urandom % 16)));
            for (int i = 0; i < 16; i++) begin tseq[i] = $urandom % 4; qseq[i] = $urandom % 4; end
            run_and_compare(tl, ql, 1 + $urandom % 6, $urandom % 5, $urandom % 5,
                            $urandom % 3, "R6 lengths");
        end
    endtask

    task automatic t_start_busy_r7();
        int bs, br, bc;
        for (int i = 0; i < 16; i++) begin tseq[i] = $urandom % 4; qseq[i] = $urandom % 4; end
        model(16, 16, 3, 1, 2, 1, bs, br, bc);
        load_all(16, 16);
        set_cfg(16, 16, 3, 1, 2, 1);
        kick();
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R7 busy during run", busy, 1);
        set_cfg(2, 2, 40, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R7 done");
        check(best_score == 16'(bs), "R7 start ignored score", best_score, bs);
        check(best_row == 5'(br) && best_col == 5'(bc), "R7 start ignored cell", best_row, br);
    endtask

    task automatic t_done_hold_r8();
        logic [15:0] s;
        logic [4:0]  r, c;
        for (int i = 0; i < 4; i++) begin tseq[i] = 3 - i; qseq[i] = 3 - i; end
        load_all(4, 4);
        set_cfg(4, 4, 2, 1, 1, 1);
        kick();
        wait_done("R8 done");
        s = best_score; r = best_row; c = best_col;
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
        write_sym(1'b0, 0, 1);
        repeat (4) @(negedge clk);
        check(best_score == s && best_row == r && best_col == c, "R8 results held", best_score, s);
        check(s == 16'd8, "R8 result value", s, 8);
    endtask

    task automatic t_zero_len_r9();
        set_cfg(0, 5, 3, 1, 1, 1);
        kick();
        check(done == 1'b1 && busy == 1'b0, "R9 empty target done", done, 1);
        check(best_score == 16'd0 && best_row == 5'd0 && best_col == 5'd0,
              "R9 empty target result", best_score, 0);
        set_cfg(4, 0, 3, 1, 1, 1);
        kick();
        check(done == 1'b1 && busy == 1'b0, "R9 empty query done", done, 1);
    endtask

    task automatic t_load_busy_r10();
        int bs, br, bc;
        for (int i = 0; i < 16; i++) begin tseq[i] = i % 4; qseq[i] = (i + 1) % 4; end
        model(16, 16, 4, 2, 3, 1, bs, br, bc);
        load_all(16, 16);
        set_cfg(16, 16, 4, 2, 3, 1);
        kick();
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 1'b1; ld_addr = 4'd5; ld_sym = 2'(qseq[5] ^ 1);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 1'b0; ld_addr = 4'd6; ld_sym = 2'(tseq[6] ^ 2);
        @(negedge clk);
        ld_en = 1'b0;
        wait_done("R10 done");
        check(best_score == 16'(bs), "R10 first run", best_score, bs);
        kick();
        wait_done("R10 rerun done");
        check(best_score == 16'(bs), "R10 stores untouched score", best_score, bs);
        check(best_row == 5'(br) && best_col == 5'(bc), "R10 stores untouched cell", best_col, bc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identical_r1();
        t_gap_r2();
        t_saturate_r3();
        t_nomatch_r4();
        t_ties_r5();
        t_lengths_r6();
        t_start_busy_r7();
        t_done_hold_r8();
        t_zero_len_r9();
        t_load_busy_r10();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule